// File: doc/BRIEF.md
# Quarter-Wave Selective-Harmonic-Elimination Level Generator

This block sets the target output level of one converter phase across each fundamental period. Each cycle with the enable tick high, a phase word grows by a programmable step. The first quarter of the wave is kept as a table of seven ascending switching angles. Every phase position is folded back into that quarter and compared with the table. The number of angles already passed selects the magnitude. Odd half-wave symmetry then gives the sign. The output is a signed level code. In three-level mode the code runs from -1 to +1, and in five-level mode it runs from -2 to +2.

The bench-facing register port writes new angles into a shadow copy. The shadow copy is checked and promoted only when the phase word wraps past zero, so a single period never mixes two tables. A shadow table whose angles are out of order or outside the open first quarter is refused. In that case the old table stays in use and an error flag is raised. The level-count mode is also taken only at the wrap. The split between the inner and outer bands in five-level mode is an elaboration parameter, and it must be odd.

Top module: `shepwm_gen`

## Requirements
- R1: On a cycle with `tick_i` high, the 16-bit phase (2^16 = 360 degrees) advances by `step_i` modulo 2^16. On a cycle with `tick_i` low, the phase and `level_o` hold.
- R2: Let q be the low 15 phase bits. The folded angle is q when q < 16384, and 32768 - q otherwise. An angle counts as passed when the folded angle is greater than or equal to it, so an exact hit switches at that phase. The level is 0 at phase 0 and at phase 32768.
- R3: In three-level mode the magnitude is 1 when an odd number of angles are passed, and 0 otherwise. `level_o` is a 3-bit two's-complement code limited to -1..+1.
- R4: In five-level mode with inner count 3, the magnitude follows the passed count c as c=0:0, 1:1, 2:0, 3:1, 4:2, 5:1, 6:2, 7:1. `level_o` is 3-bit two's complement in -2..+2.
- R5: When phase bit 15 is set, `level_o` is the negative of the magnitude found for the same low 15 bits.
- R6: A write to `wr_addr_i` 0..6 changes only the shadow entry with that index, and the output does not change before the next wrap. A write to address 7 is ignored and does not mark the shadow as pending.
- R7: On a wrap (a tick whose addition carries out of bit 15), a pending shadow that is valid replaces the active table. The new table governs the level from that same update onward. The shadow used is the one held before any write in that cycle.
- R8: A shadow is valid only when angle0 > 0, each angle is strictly larger than the one before it, and angle6 < 16384. An invalid pending shadow leaves the active table unchanged and sets `tbl_err_o`, and the next accepted commit clears it.
- R9: `mode_five_i` (1 = five-level) is sampled only on a wrap, and changes between wraps do not affect `level_o`.
- R10: After reset the phase is 0, `level_o` is 0, `tbl_err_o` is 0, the mode is three-level, and the active and shadow tables hold 2048*(i+1) for index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Phase advance enable |
| step_i | input | 16 | Phase increment per tick |
| mode_five_i | input | 1 | Requested mode, 1 = five-level, taken at wrap |
| wr_en_i | input | 1 | Shadow table write strobe |
| wr_addr_i | input | 3 | Shadow entry index |
| wr_data_i | input | 16 | Angle value in phase units |
| level_o | output | 3 | Signed level code |
| tbl_err_o | output | 1 | Last commit attempt was refused |

## Verification
A step of 64 puts the phase exactly on every angle of the default table and on both half-period points. This separates a passed-or-equal comparison from a strictly-greater one, and it checks the quarter mirror at the 90-degree point. A step of 96, and a run with gaps in the tick, make the wrap fall at uneven positions and pause the phase, so wrap detection and hold behaviour are tested apart from the table lookup. Five-level sweeps with a non-uniform table tell the inner-band toggles apart from the outer-band toggles. Several tables are each broken in one way: out of order, a zero angle, and an angle at 90 degrees. Each is followed by a repaired table, and these runs, together with a mode flip in mid-period, show that commits and rejections happen only at the period boundary.

// File: rtl/shepwm_pkg.sv
package shepwm_pkg;

    // number of switching angles per quarter wave used by the scheme
    localparam int unsigned ANGLES_PER_QUARTER = 7;

    typedef enum logic {
        LVL_THREE = 1'b0,
        LVL_FIVE  = 1'b1
    } lvl_mode_e;

endpackage

// File: rtl/shepwm_phase.sv
module shepwm_phase #(
    parameter int unsigned PH_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [PH_W-1:0] step_i,
    output logic [PH_W-1:0] phase_o,
    output logic [PH_W-1:0] phase_nxt_o,
    output logic            wrap_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic [PH_W:0] sum;

    always_comb begin
        st_d   = st_q;
        sum    = {1'b0, st_q.phase} + {1'b0, step_i};
        wrap_o = tick_i & sum[PH_W];
        if (tick_i) begin
            st_d.phase = sum[PH_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o     = st_q.phase;
    assign phase_nxt_o = st_d.phase;

endmodule

// File: rtl/shepwm_table.sv
module shepwm_table
    import shepwm_pkg::*;
#(
    parameter int unsigned PH_W  = 16,
    parameter int unsigned N_ANG = ANGLES_PER_QUARTER,
    localparam int unsigned AW   = $clog2(N_ANG + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [PH_W-1:0]           wr_data_i,
    input  logic                      wrap_i,
    input  logic                      mode_i,
    output logic [N_ANG-1:0][PH_W-1:0] act_tbl_o,
    output logic [N_ANG-1:0][PH_W-1:0] act_tbl_nxt_o,
    output lvl_mode_e                 mode_o,
    output lvl_mode_e                 mode_nxt_o,
    output logic                      pending_o,
    output logic                      shadow_ok_o,
    output logic                      err_o
);

    localparam int unsigned QUARTER = 1 << (PH_W - 2);
    localparam int unsigned DEF_GAP = QUARTER / (N_ANG + 1);

    typedef logic [N_ANG-1:0][PH_W-1:0] tbl_t;

    typedef struct packed {
        tbl_t      shadow;
        tbl_t      act;
        lvl_mode_e mode;
        logic      pend;
        logic      err;
    } tb_st_t;

    function automatic tbl_t make_default();
        tbl_t t;
        for (int i = 0; i < int'(N_ANG); i++) begin
            t[i] = PH_W'((i + 1) * DEF_GAP);
        end
        return t;
    endfunction

    localparam tbl_t DEF_TBL = make_default();

    tb_st_t st_d, st_q;
    logic [N_ANG-1:0] order_ok;
    logic             upper_ok;

    // per-entry ordering checks on the shadow copy
    for (genvar g = 0; g < int'(N_ANG); g++) begin : g_order
        if (g == 0) begin : g_first
            assign order_ok[g] = (st_q.shadow[g] != '0);
        end else begin : g_rest
            assign order_ok[g] = (st_q.shadow[g] > st_q.shadow[g-1]);
        end
    end

    assign upper_ok    = (st_q.shadow[N_ANG-1][PH_W-1:PH_W-2] == 2'b00);
    assign shadow_ok_o = (&order_ok) & upper_ok;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.mode = lvl_mode_e'(mode_i);
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (shadow_ok_o) begin
                    st_d.act = st_q.shadow;
                    st_d.err = 1'b0;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end
        if (wr_en_i && (int'(wr_addr_i) < int'(N_ANG))) begin
            st_d.shadow[wr_addr_i] = wr_data_i;
            st_d.pend              = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= DEF_TBL;
            st_q.act    <= DEF_TBL;
            st_q.mode   <= LVL_THREE;
            st_q.pend   <= 1'b0;
            st_q.err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_tbl_o     = st_q.act;
    assign act_tbl_nxt_o = st_d.act;
    assign mode_o        = st_q.mode;
    assign mode_nxt_o    = st_d.mode;
    assign pending_o     = st_q.pend;
    assign err_o         = st_q.err;

endmodule

// File: rtl/shepwm_level.sv
module shepwm_level
    import shepwm_pkg::*;
#(
    parameter int unsigned PH_W    = 16,
    parameter int unsigned N_ANG   = ANGLES_PER_QUARTER,
    parameter int unsigned K_INNER = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [PH_W-1:0]            phase_i,
    input  logic [N_ANG-1:0][PH_W-1:0] tbl_i,
    input  lvl_mode_e                  mode_i,
    output logic [2:0]                 level_o
);

    localparam int unsigned CW     = $clog2(N_ANG + 1);
    localparam logic [PH_W-1:0] HALF_W = {1'b1, {(PH_W-1){1'b0}}};
    localparam logic       K_ODD  = ((K_INNER % 2) == 1);

    if ((K_INNER % 2) == 0 || K_INNER >= N_ANG) begin : g_bad_split
        $error("inner transition count must be odd and below the angle count");
    end

    typedef struct packed {
        logic [2:0] level;
    } lv_st_t;

    lv_st_t st_d, st_q;

    logic [PH_W-2:0]  q;
    logic [PH_W-1:0]  fold;
    logic [N_ANG-1:0] passed;
    logic [CW-1:0]    cnt;
    logic [1:0]       mag;

    assign q    = phase_i[PH_W-2:0];
    assign fold = q[PH_W-2] ? (HALF_W - {1'b0, q}) : {1'b0, q};

    for (genvar g = 0; g < int'(N_ANG); g++) begin : g_cmp
        assign passed[g] = (fold >= tbl_i[g]);
    end

    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(N_ANG); i++) begin
            cnt = cnt + CW'(passed[i]);
        end
    end

    always_comb begin
        st_d = st_q;
        if (mode_i == LVL_THREE || cnt <= CW'(K_INNER)) begin
            mag = {1'b0, cnt[0]};
        end else begin
            mag = (cnt[0] ^ K_ODD) ? 2'd2 : 2'd1;
        end
        if (phase_i[PH_W-1]) begin
            st_d.level = 3'd0 - {1'b0, mag};
        end else begin
            st_d.level = {1'b0, mag};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;

endmodule

// File: rtl/shepwm_gen.sv
module shepwm_gen
    import shepwm_pkg::*;
#(
    parameter int unsigned PH_W    = 16,
    parameter int unsigned N_ANG   = ANGLES_PER_QUARTER,
    parameter int unsigned K_INNER = 3,
    localparam int unsigned AW     = $clog2(N_ANG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic [PH_W-1:0] step_i,
    input  logic            mode_five_i,
    input  logic            wr_en_i,
    input  logic [AW-1:0]   wr_addr_i,
    input  logic [PH_W-1:0] wr_data_i,
    output logic [2:0]      level_o,
    output logic            tbl_err_o
);

    logic [PH_W-1:0]            phase;
    logic [PH_W-1:0]            phase_nxt;
    logic                       wrap;
    logic [N_ANG-1:0][PH_W-1:0] act_tbl;
    logic [N_ANG-1:0][PH_W-1:0] act_tbl_nxt;
    lvl_mode_e                  mode_act;
    lvl_mode_e                  mode_nxt;
    logic                       pending;
    logic                       shadow_ok;

    shepwm_phase #(.PH_W(PH_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .step_i      (step_i),
        .phase_o     (phase),
        .phase_nxt_o (phase_nxt),
        .wrap_o      (wrap)
    );

    shepwm_table #(.PH_W(PH_W), .N_ANG(N_ANG)) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .wrap_i        (wrap),
        .mode_i        (mode_five_i),
        .act_tbl_o     (act_tbl),
        .act_tbl_nxt_o (act_tbl_nxt),
        .mode_o        (mode_act),
        .mode_nxt_o    (mode_nxt),
        .pending_o     (pending),
        .shadow_ok_o   (shadow_ok),
        .err_o         (tbl_err_o)
    );

    shepwm_level #(.PH_W(PH_W), .N_ANG(N_ANG), .K_INNER(K_INNER)) u_level (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_nxt),
        .tbl_i   (act_tbl_nxt),
        .mode_i  (mode_nxt),
        .level_o (level_o)
    );

endmodule

// File: rtl/shepwm_gen_chk.sv
module shepwm_gen_chk #(
    parameter int unsigned PH_W  = 16,
    parameter int unsigned N_ANG = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_i,
    input logic [2:0]            level_o,
    input logic                  tbl_err_o,
    input logic                  wrap,
    input logic                  mode_act,
    input logic                  pending,
    input logic                  shadow_ok,
    input logic [PH_W-1:0]       phase,
    input logic [N_ANG*PH_W-1:0] act_tbl
);

    localparam logic [PH_W-1:0] HALF_W = {1'b1, {(PH_W-1){1'b0}}};

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(level_o));

    assert_zero_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == '0 || phase == HALF_W) |-> level_o == 3'd0);

    assert_three_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_act |-> (level_o == 3'd0 || level_o == 3'd1 || level_o == 3'd7));

    assert_code_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_o != 3'd3 && level_o != 3'd4 && level_o != 3'd5);

    assert_commit_at_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_tbl));

    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pending && !shadow_ok) |=> (tbl_err_o && $stable(act_tbl)));

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && pending && shadow_ok) |=> !tbl_err_o);

    assert_mode_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mode_act));

endmodule

bind shepwm_gen shepwm_gen_chk #(.PH_W(PH_W), .N_ANG(N_ANG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .level_o   (level_o),
    .tbl_err_o (tbl_err_o),
    .wrap      (wrap),
    .mode_act  (mode_act),
    .pending   (pending),
    .shadow_ok (shadow_ok),
    .phase     (phase),
    .act_tbl   (act_tbl)
);

// File: tb/sim_shepwm_gen.sv
`timescale 1ns/1ps
module sim_shepwm_gen;

    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] step = '0;
    logic        mode_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  level_o;
    logic        tbl_err_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int  m_ph;
    int  m_act[7];
    int  m_shd[7];
    bit  m_pend;
    bit  m_err;
    bit  m_five;

    always #(CLK_P/2) clk = ~clk;

    shepwm_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .step_i      (step),
        .mode_five_i (mode_in),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .level_o     (level_o),
        .tbl_err_o   (tbl_err_o)
    );

    function automatic bit shd_valid();
        if (m_shd[0] <= 0) return 0;
        for (int i = 1; i < 7; i++) if (m_shd[i] <= m_shd[i-1]) return 0;
        return m_shd[6] < 16384;
    endfunction

    function automatic int ref_level();
        int q, a, c, mag;
        q = m_ph % 32768;
        a = (q < 16384) ? q : 32768 - q;
        c = 0;
        for (int i = 0; i < 7; i++) if (a >= m_act[i]) c++;
        if (!m_five || c <= 3) mag = c % 2;
        else mag = ((c - 3) % 2 == 1) ? 2 : 1;
        return (m_ph >= 32768) ? -mag : mag;
    endfunction

    task automatic compare(input string tag);
        int got, exp;
        got = int'($signed(level_o));
        exp = ref_level();
        checks++;
        if (got != exp || tbl_err_o != m_err) begin
            fails++;
            $display("FAIL %s phase=%0d level got %0d exp %0d err got %0d exp %0d",
                     tag, m_ph, got, exp, tbl_err_o, m_err);
        end
    endtask

    task automatic cyc(input bit tk, input int st, input bit we, input int ad,
                       input int dat, input string tag);
        int  nph;
        bit  wrp;
        tick    = tk;
        step    = st[15:0];
        wr_en   = we;
        wr_addr = ad[2:0];
        wr_data = dat[15:0];
        @(posedge clk);
        nph  = m_ph + (tk ? st : 0);
        wrp  = tk && (nph >= 65536);
        m_ph = nph % 65536;
        if (wrp) begin
            m_five = mode_in;
            if (m_pend) begin
                m_pend = 0;
                if (shd_valid()) begin
                    for (int i = 0; i < 7; i++) m_act[i] = m_shd[i];
                    m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
        if (we && ad < 7) begin
            m_shd[ad] = dat;
            m_pend    = 1;
        end
        @(negedge clk);
        wr_en = 1'b0;
        compare(tag);
    endtask

    task automatic run(input int n, input int st, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, st, 1'b0, 0, 0, tag);
    endtask

    task automatic put(input int ad, input int dat, input string tag);
        cyc(1'b1, 64, 1'b1, ad, dat, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, got hang exp completion");
            summary();
            $finish;
        end
    end

    initial begin
        m_ph = 0; m_pend = 0; m_err = 0; m_five = 0;
        for (int i = 0; i < 7; i++) begin
            m_act[i] = 2048 * (i + 1);
            m_shd[i] = 2048 * (i + 1);
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        compare("R10 reset state");

        // R1: no tick, phase and level hold even with a large step
        for (int i = 0; i < 8; i++) cyc(1'b0, 5000, 1'b0, 0, 0, "R1 hold");
        // R2/R3: step 64 lands exactly on each default angle and on 90/180 degrees
        run(1100, 64, "R2 R3 exact-hit sweep");
        // R5: negative half-wave over an uneven wrap position
        run(1500, 96, "R5 R1 uneven sweep");
        // R1: gapped ticks
        for (int i = 0; i < 900; i++) cyc(i % 3 != 0, 101, 1'b0, 0, 0, "R1 gapped tick");

        // R6/R7/R9: stage a five-level table; nothing changes before the wrap
        mode_in = 1'b1;
        put(0, 1000,  "R6 stage");
        put(1, 3000,  "R6 stage");
        put(2, 5000,  "R6 stage");
        put(3, 7000,  "R6 stage");
        put(4, 9000,  "R6 stage");
        put(5, 12000, "R6 stage");
        put(6, 16000, "R6 stage");
        put(7, 0,     "R6 ignored address");
        run(1100, 64, "R7 R9 commit");
        run(1100, 37, "R4 five-level sweep");

        // R8: out-of-order entry is refused, old table kept
        put(3, 800, "R8 stage bad order");
        run(1100, 64, "R8 reject order");
        put(3, 7000, "R8 repair");
        run(1100, 64, "R8 accept clears flag");
        // R8: zero angle
        put(0, 0, "R8 stage zero");
        run(1100, 64, "R8 reject zero");
        put(0, 1000, "R8 repair zero");
        run(1100, 64, "R8 accept zero repaired");
        // R8: angle at 90 degrees
        put(6, 16384, "R8 stage top");
        run(1100, 64, "R8 reject top");
        put(6, 16383, "R8 repair top");
        run(1100, 64, "R8 accept top repaired");

        // R9: mode flipped mid-period only applies at the wrap
        run(300, 64, "R9 pre");
        mode_in = 1'b0;
        run(1100, 64, "R9 mode at wrap");
        run(700, 53, "R3 three-level custom table");

        done = 1;
        summary();
        $finish;
    end

endmodule